// File: doc/BRIEF.md
# Escaped Serial Frame Receiver

This block sits behind a byte-wide serial receiver and recovers framed packets from the incoming byte stream. It accepts one byte on each cycle where `in_valid` is high, and it cannot apply backpressure. The escape byte (0x10) has three uses in the stream. Followed by 0x02, it opens a frame. Followed by 0x03, it closes a frame. Followed by a second 0x10, it stands for one literal 0x10 payload byte. Bytes that arrive outside a frame are discarded.

Recovered payload bytes leave in stream order on `out_valid` and `out_byte`. `out_sof` marks the first byte of a frame and `out_eof` marks the last. The block knows which byte is last only when the closing pair arrives, so it holds every payload byte back by one input beat. The byte that follows the closing pair is a one-byte check. It must be the two's complement of the modulo-256 sum of the unescaped payload. After that byte, the block pulses `frame_good` or `frame_bad` for one cycle. If the escape byte is followed by any other value, the frame is dropped and `frame_bad` pulses.

Top module: `dle_frame_rx`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `out_valid`, `out_sof`, `out_eof`, `frame_good` and `frame_bad` are all 0.
- R2: Bytes outside a frame produce no output. A frame opens only when 0x02 directly follows 0x10. A 0x10 followed by any other byte outside a frame opens nothing.
- R3: Each payload byte appears exactly once on `out_byte` with `out_valid` high, in arrival order. `out_sof` is high with the first byte of the frame and `out_eof` is high with the last. A frame with no payload emits nothing.
- R4: The pair 0x10 0x10 inside a frame is delivered as a single 0x10 payload byte.
- R5: The byte after the closing 0x10 0x03 is the check byte. If the payload sum plus the check byte is 0x00 modulo 256, `frame_good` pulses for one cycle. Otherwise `frame_bad` pulses for one cycle.
- R6: A doubled 0x10 adds 0x10 to the sum only once. For the payload 08 00 01 00 00 80 02 10 the sum is 0x9B, so only the check byte 0x65 gives `frame_good`.
- R7: The pair 0x10 0x02 inside a frame discards the partial frame and starts a new one. The byte still held back is never delivered, the sum restarts from zero, and no pulse is raised.
- R8: Inside a frame, 0x10 followed by any byte other than 0x02, 0x03 or 0x10 pulses `frame_bad` and drops the held-back byte. The receiver then waits for a new opening pair, so the next byte is not taken as a check byte.
- R9: A cycle with `in_valid` low has no effect, whatever value `in_byte` carries.
- R10: A held-back payload byte appears on the clock after the input beat that releases it, which is the next payload byte or the 0x03 of the closing pair. A pulse appears on the clock after the check byte or after the bad escape. `frame_good` and `frame_bad` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | `in_byte` carries a stream byte this cycle |
| in_byte | input | 8 | Stream byte |
| out_valid | output | 1 | Recovered payload byte valid |
| out_byte | output | 8 | Recovered payload byte |
| out_sof | output | 1 | First payload byte of the frame |
| out_eof | output | 1 | Last payload byte of the frame |
| frame_good | output | 1 | One-cycle pulse: check byte matched |
| frame_bad | output | 1 | One-cycle pulse: check byte mismatched or bad escape |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, escape 0x10, open 0x02 and close 0x03. The random payload bytes are biased toward those three values. This makes doubled escapes, literal 0x02 and 0x03 inside payloads, and escape-then-close sequences common. Idle cycles with junk on `in_byte` are inserted at random. Directed cases cover the worked checksum example, empty frames, a restart inside a frame, a bad escape followed by a stray byte, and the exact cycle on which the last byte and the pulse appear.

// File: rtl/dle_rx_pkg.sv
package dle_rx_pkg;
  typedef enum logic [2:0] {
    ST_HUNT     = 3'd0,
    ST_HUNT_ESC = 3'd1,
    ST_BODY     = 3'd2,
    ST_BODY_ESC = 3'd3,
    ST_CHECK    = 3'd4
  } rx_state_t;
endpackage

// File: rtl/dle_frame_fsm.sv
module dle_frame_fsm
  import dle_rx_pkg::*;
#(
  parameter int                BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] DLE_CODE = 'h10,
  parameter logic [BYTE_W-1:0] STX_CODE = 'h02,
  parameter logic [BYTE_W-1:0] ETX_CODE = 'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              pay_stb,
  output logic [BYTE_W-1:0] pay_byte,
  output logic              open_stb,
  output logic              close_stb,
  output logic              abort_stb,
  output logic              chk_stb
);
  rx_state_t state_q, state_d;
  logic      is_dle, is_stx, is_etx;

  assign is_dle   = (in_byte == DLE_CODE);
  assign is_stx   = (in_byte == STX_CODE);
  assign is_etx   = (in_byte == ETX_CODE);
  assign pay_byte = in_byte;

  always_comb begin
    state_d   = state_q;
    pay_stb   = 1'b0;
    open_stb  = 1'b0;
    close_stb = 1'b0;
    abort_stb = 1'b0;
    chk_stb   = 1'b0;
    if (in_valid) begin
      case (state_q)
        ST_HUNT: begin
          if (is_dle) state_d = ST_HUNT_ESC;
        end
        ST_HUNT_ESC: begin
          if (is_stx) begin
            open_stb = 1'b1;
            state_d  = ST_BODY;
          end else if (!is_dle) begin
            state_d  = ST_HUNT;
          end
        end
        ST_BODY: begin
          if (is_dle) state_d = ST_BODY_ESC;
          else        pay_stb = 1'b1;
        end
        ST_BODY_ESC: begin
          if (is_dle) begin
            pay_stb   = 1'b1;
            state_d   = ST_BODY;
          end else if (is_stx) begin
            open_stb  = 1'b1;
            state_d   = ST_BODY;
          end else if (is_etx) begin
            close_stb = 1'b1;
            state_d   = ST_CHECK;
          end else begin
            abort_stb = 1'b1;
            state_d   = ST_HUNT;
          end
        end
        ST_CHECK: begin
          chk_stb = 1'b1;
          state_d = ST_HUNT;
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_HUNT;
    else if (in_valid) state_q <= state_d;
  end

  assert_idle_holds_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(state_q));

  assert_check_is_one_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && state_q == ST_CHECK) |=> (state_q == ST_HUNT));

  assert_single_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pay_stb, open_stb, close_stb, abort_stb, chk_stb}));
endmodule

// File: rtl/dle_hold_stage.sv
module dle_hold_stage #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pay_stb,
  input  logic [BYTE_W-1:0] pay_byte,
  input  logic              open_stb,
  input  logic              close_stb,
  input  logic              abort_stb,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_sof,
  output logic              out_eof
);
  logic              pend_vld_q, pend_vld_d;
  logic [BYTE_W-1:0] pend_byte_q, pend_byte_d;
  logic              pend_first_q, pend_first_d;
  logic              seen_q, seen_d;
  logic              emit, emit_eof, pend_en;

  assign pend_en = pay_stb | open_stb | close_stb | abort_stb;

  always_comb begin
    pend_vld_d   = pend_vld_q;
    pend_byte_d  = pend_byte_q;
    pend_first_d = pend_first_q;
    seen_d       = seen_q;
    emit         = 1'b0;
    emit_eof     = 1'b0;
    if (open_stb || abort_stb) begin
      pend_vld_d = 1'b0;
      seen_d     = 1'b0;
    end else if (pay_stb) begin
      emit         = pend_vld_q;
      pend_vld_d   = 1'b1;
      pend_byte_d  = pay_byte;
      pend_first_d = !seen_q;
      seen_d       = 1'b1;
    end else if (close_stb) begin
      emit       = pend_vld_q;
      emit_eof   = pend_vld_q;
      pend_vld_d = 1'b0;
      seen_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld_q   <= 1'b0;
      pend_byte_q  <= '0;
      pend_first_q <= 1'b0;
      seen_q       <= 1'b0;
    end else if (pend_en) begin
      pend_vld_q   <= pend_vld_d;
      pend_byte_q  <= pend_byte_d;
      pend_first_q <= pend_first_d;
      seen_q       <= seen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else begin
      out_valid <= emit;
      out_sof   <= emit & pend_first_q;
      out_eof   <= emit_eof;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    out_byte <= '0;
    else if (emit) out_byte <= pend_byte_q;
  end

  assert_eof_carries_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid);

  assert_sof_carries_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  assert_pending_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_en |=> $stable(pend_vld_q) && $stable(pend_byte_q));

  assert_drop_on_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (open_stb || abort_stb) |=> !out_valid && !pend_vld_q);
endmodule

// File: rtl/dle_sum_check.sv
module dle_sum_check #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pay_stb,
  input  logic [BYTE_W-1:0] pay_byte,
  input  logic              open_stb,
  input  logic              abort_stb,
  input  logic              chk_stb,
  input  logic [BYTE_W-1:0] chk_byte,
  output logic              frame_good,
  output logic              frame_bad
);
  localparam int SUM_W = BYTE_W;

  logic [SUM_W-1:0] sum_q, sum_d, total;
  logic             sum_en, good_d, bad_d;

  assign sum_en = pay_stb | open_stb | abort_stb;
  assign total  = sum_q + chk_byte;

  always_comb begin
    sum_d = sum_q;
    if (open_stb || abort_stb) sum_d = '0;
    else if (pay_stb)          sum_d = sum_q + pay_byte;
  end

  always_comb begin
    good_d = chk_stb && (total == '0);
    bad_d  = (chk_stb && (total != '0)) || abort_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (sum_en) sum_q <= sum_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_good <= 1'b0;
      frame_bad  <= 1'b0;
    end else begin
      frame_good <= good_d;
      frame_bad  <= bad_d;
    end
  end

  assert_verdict_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_good && frame_bad));

  assert_good_is_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_good |=> !frame_good);

  assert_bad_is_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |=> !frame_bad);

  assert_sum_cleared_on_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    open_stb |=> (sum_q == '0));
endmodule

// File: rtl/dle_frame_rx.sv
module dle_frame_rx #(
  parameter int                BYTE_W   = 8,
  parameter logic [BYTE_W-1:0] DLE_CODE = 'h10,
  parameter logic [BYTE_W-1:0] STX_CODE = 'h02,
  parameter logic [BYTE_W-1:0] ETX_CODE = 'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_sof,
  output logic              out_eof,
  output logic              frame_good,
  output logic              frame_bad
);
  logic              pay_stb, open_stb, close_stb, abort_stb, chk_stb;
  logic [BYTE_W-1:0] pay_byte;

  dle_frame_fsm #(
    .BYTE_W  (BYTE_W),
    .DLE_CODE(DLE_CODE),
    .STX_CODE(STX_CODE),
    .ETX_CODE(ETX_CODE)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .pay_stb  (pay_stb),
    .pay_byte (pay_byte),
    .open_stb (open_stb),
    .close_stb(close_stb),
    .abort_stb(abort_stb),
    .chk_stb  (chk_stb)
  );

  dle_hold_stage #(.BYTE_W(BYTE_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .pay_stb  (pay_stb),
    .pay_byte (pay_byte),
    .open_stb (open_stb),
    .close_stb(close_stb),
    .abort_stb(abort_stb),
    .out_valid(out_valid),
    .out_byte (out_byte),
    .out_sof  (out_sof),
    .out_eof  (out_eof)
  );

  dle_sum_check #(.BYTE_W(BYTE_W)) u_sum (
    .clk       (clk),
    .rst_n     (rst_n),
    .pay_stb   (pay_stb),
    .pay_byte  (pay_byte),
    .open_stb  (open_stb),
    .abort_stb (abort_stb),
    .chk_stb   (chk_stb),
    .chk_byte  (in_byte),
    .frame_good(frame_good),
    .frame_bad (frame_bad)
  );

  assert_output_needs_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || frame_good || frame_bad) |-> $past(in_valid));
endmodule

// File: tb/dle_frame_rx_tb.sv
`timescale 1ns/1ps
module dle_frame_rx_tb;
  localparam logic [7:0] DLE = 8'h10;
  localparam logic [7:0] STX = 8'h02;
  localparam logic [7:0] ETX = 8'h03;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_byte;
  logic       out_valid, out_sof, out_eof, frame_good, frame_bad;
  logic [7:0] out_byte;

  int tests = 0;
  int fails = 0;
  bit gaps  = 1'b0;

  logic [9:0] exp_q[$];
  logic [9:0] act_q[$];
  logic [1:0] exp_p[$];
  logic [1:0] act_p[$];

  always #2 clk = ~clk;

  dle_frame_rx u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_byte(out_byte), .out_sof(out_sof),
    .out_eof(out_eof), .frame_good(frame_good), .frame_bad(frame_bad)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid)  act_q.push_back({out_sof, out_eof, out_byte});
      if (frame_good) act_p.push_back(2'b01);
      if (frame_bad)  act_p.push_back(2'b10);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bcc(input logic [7:0] q[$]);
    logic [7:0] s = 8'h00;
    foreach (q[i]) s = s + q[i];
    return 8'h00 - s;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0;
      in_byte  = 8'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    if (gaps && ($urandom_range(0, 3) == 0)) idle($urandom_range(1, 2));
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_pay(input logic [7:0] b);
    if (b == DLE) send_byte(DLE);
    send_byte(b);
  endtask

  task automatic expect_payload(input logic [7:0] q[$]);
    foreach (q[i]) exp_q.push_back({(i == 0), (i == q.size() - 1), q[i]});
  endtask

  task automatic send_frame(input logic [7:0] q[$], input logic [7:0] chk);
    send_byte(DLE); send_byte(STX);
    foreach (q[i]) send_pay(q[i]);
    send_byte(DLE); send_byte(ETX);
    send_byte(chk);
  endtask

  task automatic compare(input string tag);
    idle(4);
    check(act_q.size() == exp_q.size(), {tag, " byte count"}, act_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < act_q.size(); i++)
      check(act_q[i] === exp_q[i], {tag, " byte/sof/eof"}, act_q[i], exp_q[i]);
    check(act_p.size() == exp_p.size(), {tag, " pulse count"}, act_p.size(), exp_p.size());
    for (int i = 0; i < exp_p.size() && i < act_p.size(); i++)
      check(act_p[i] === exp_p[i], {tag, " pulse kind"}, act_p[i], exp_p[i]);
    exp_q.delete(); act_q.delete(); exp_p.delete(); act_p.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    logic [7:0] chk;
    int unsigned seed;
    seed = $urandom(32'h1bad5eed);
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
    repeat (3) @(negedge clk);
    check({out_valid, out_sof, out_eof, frame_good, frame_bad} == 5'b0,
          "R1 outputs in reset", {out_valid, out_sof, out_eof, frame_good, frame_bad}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({out_valid, out_sof, out_eof, frame_good, frame_bad} == 5'b0,
          "R1 outputs after release", {out_valid, out_sof, out_eof, frame_good, frame_bad}, 0);

    // R2: junk outside frames, including a lone escape and a bare STX
    send_byte(8'h55); send_byte(DLE); send_byte(8'h41); send_byte(ETX);
    send_byte(STX); send_byte(8'hA7);
    compare("R2 junk ignored");

    // R6: worked checksum example, the doubled escape counted once
    q = '{8'h08, 8'h00, 8'h01, 8'h00, 8'h00, 8'h80, 8'h02, 8'h10};
    check(bcc(q) == 8'h65, "R6 bench checksum", bcc(q), 8'h65);
    send_frame(q, 8'h65); expect_payload(q); exp_p.push_back(2'b01);
    compare("R6 example good");
    send_frame(q, 8'h75); expect_payload(q); exp_p.push_back(2'b10);
    compare("R6 example wrong check");

    // R4: doubled escape bytes back to back
    q = '{8'h10, 8'h10};
    send_frame(q, 8'hE0); expect_payload(q); exp_p.push_back(2'b01);
    compare("R4 doubled escapes");

    // R3: empty frames emit no bytes
    q.delete();
    send_frame(q, 8'h00); exp_p.push_back(2'b01);
    compare("R3 empty good");
    send_frame(q, 8'h01); exp_p.push_back(2'b10);
    compare("R5 empty bad");

    // R10: exact cycle of the last byte and the pulse, no gaps
    send_byte(DLE); send_byte(STX); send_byte(8'h3C); send_byte(8'h5A);
    send_byte(DLE); send_byte(ETX);
    check(out_valid && out_eof && !out_sof && out_byte == 8'h5A,
          "R10 last byte on clock after close", {out_valid, out_eof, out_sof, out_byte}, 11'h65A);
    send_byte(8'h6A);
    check(frame_good && !frame_bad, "R10 good on clock after check", {frame_good, frame_bad}, 2'b10);
    @(negedge clk);
    check(!frame_good, "R5 good lasts one cycle", frame_good, 0);
    exp_q.push_back({2'b10, 8'h3C}); exp_q.push_back({2'b01, 8'h5A}); exp_p.push_back(2'b01);
    compare("R3 two-byte frame");

    // R7: restart inside a frame
    send_byte(DLE); send_byte(STX); send_byte(8'hA1); send_byte(8'hA2);
    send_byte(DLE); send_byte(STX); send_byte(8'hC1);
    send_byte(DLE); send_byte(ETX); send_byte(8'h3F);
    exp_q.push_back({2'b10, 8'hA1}); exp_q.push_back({2'b11, 8'hC1}); exp_p.push_back(2'b01);
    compare("R7 restart");

    // R8: bad escape, then a stray byte that must not act as a check byte
    send_byte(DLE); send_byte(STX); send_byte(8'h11); send_byte(8'h22);
    send_byte(DLE); send_byte(8'h55);
    check(frame_bad && !frame_good, "R8 bad pulse on clock after escape", {frame_good, frame_bad}, 2'b01);
    send_byte(8'h00);
    exp_q.push_back({2'b10, 8'h11}); exp_p.push_back(2'b10);
    compare("R8 bad escape");

    // R9: random idle gaps with junk; R3/R5 random frames
    gaps = 1'b1;
    for (int f = 0; f < 60; f++) begin
      int len;
      bit good;
      q.delete();
      len = $urandom_range(0, 12);
      for (int i = 0; i < len; i++) begin
        case ($urandom_range(0, 7))
          0:       q.push_back(DLE);
          1:       q.push_back(STX);
          2:       q.push_back(ETX);
          default: q.push_back(8'($urandom));
        endcase
      end
      good = ($urandom_range(0, 3) != 0);
      chk  = good ? bcc(q) : bcc(q) + 8'($urandom_range(1, 255));
      if ($urandom_range(0, 2) == 0) send_byte(8'($urandom_range(32, 255)));
      send_frame(q, chk);
      expect_payload(q);
      exp_p.push_back(good ? 2'b01 : 2'b10);
      compare("R9 R3 R5 random frame");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule